// File: doc/BRIEF.md
# Twelve-line GPIO controller with latched level interrupts

This block is a small register-mapped GPIO controller. Software reaches eight 32-bit registers through a plain word-addressed bus: a word index, a write strobe, write data and read data that can be sampled combinationally. Each of the twelve lines has three parts:

- an output value bit,
- a drive-enable bit,
- an input bit that passes through a two-flop synchronizer.

The synchronized input feeds both the input register and the interrupt logic.

Each line can raise a level-sensitive interrupt, and a per-line polarity bit picks its active level. While a line sits at its active level, its pending bit in the status register sets. Writing a one to that bit clears it. If the level is still present, the bit sets again on the following cycle, so software must remove the cause before it acknowledges. An enable register gates which pending bits reach the single interrupt output. A pin-mux word is only stored and read back.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_out`, `pin_oe` and `irq` are low, and every line's polarity bit is 0.
- R2: Word 0 (byte offset 0x00) holds the output values and word 1 (0x04) holds the drive enables. Bit n of each drives `pin_out[n]` / `pin_oe[n]`, where `pin_oe` high means the line is driven. Both words read back what was written.
- R3: Word 2 (0x08) returns `pin_in` through a two-stage synchronizer. A change applied before a rising edge is not visible after that one edge. It is visible after the second edge.
- R4: Bit n of word 3 (0x0C, status) sets on the edge after the synchronized line n is at its active level. It sets whatever the enable bit is, and it stays set after the level goes away.
- R5: Writing word 3 clears each status bit whose write-data bit is 1 and leaves the others alone. In that cycle the clear wins over a new set.
- R6: If line n is still active when its status bit is cleared, the bit reads 0 right after the clearing edge and reads 1 again after the next edge.
- R7: Line n takes its polarity from bit 4*(n mod 8). Lines 0–7 use word 4 (0x10) and lines 8–11 use word 6 (0x18). Polarity 0 means active high and 1 means active low. The other bits of these words have no effect on detection.
- R8: Word 5 (0x14) is the interrupt enable. `irq` is high exactly when some bit is set in both status and enable, with no added register delay.
- R9: Word 7 (0x1C, mux control) stores all 32 written bits and reads them back. It changes nothing else.
- R10: Bits 31:12 of words 0, 1, 2, 3 and 5 read zero. Word 6 bits 16, 20, 24 and 28 read zero. All other bits of words 4 and 6 store and read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 12 | Asynchronous line levels |
| pin_out | output | 12 | Output value per line |
| pin_oe | output | 12 | Drive enable per line |
| irq | output | 1 | Combined interrupt |

## Verification
The synchronizer assertion assumes `pin_in` may change at any cycle but is sampled only after a full non-reset cycle. The status assertions assume the write strobe is only meaningful while reset is released. The bench changes pins only at falling edges and holds each pin pattern and each polarity setting for at least one rising edge. Because of that, every intermediate active level really latches and the bench's steady-state model of the status register stays exact. Clears are issued only through single-cycle writes, so each write-one-to-clear event lands on a known edge.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int unsigned REG_W          = 32;
  localparam int unsigned WORD_AW        = 3;
  localparam int unsigned FIELD_STRIDE   = 4;
  localparam int unsigned LINES_PER_TYPE = 8;

  typedef enum logic [WORD_AW-1:0] {
    RG_DOUT  = 3'd0,
    RG_OE    = 3'd1,
    RG_DIN   = 3'd2,
    RG_STAT  = 3'd3,
    RG_TYPE0 = 3'd4,
    RG_EN    = 3'd5,
    RG_TYPE1 = 3'd6,
    RG_MUX   = 3'd7
  } reg_sel_e;

  // Storage mask of a type word: polarity bits of absent lines are held at 0.
  function automatic logic [REG_W-1:0] type_keep_mask(input int unsigned regidx,
                                                     input int unsigned nlines);
    logic [REG_W-1:0] m;
    m = '1;
    for (int unsigned k = 0; k < LINES_PER_TYPE; k++) begin
      if (regidx * LINES_PER_TYPE + k >= nlines) m[k*FIELD_STRIDE] = 1'b0;
    end
    return m;
  endfunction

  // Polarity bit of one line, picked from the two type words.
  function automatic logic pol_bit(input logic [REG_W-1:0] t0,
                                   input logic [REG_W-1:0] t1,
                                   input int unsigned line);
    int unsigned pos;
    pos = FIELD_STRIDE * (line % LINES_PER_TYPE);
    return (line < LINES_PER_TYPE) ? t0[pos] : t1[pos];
  endfunction
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic             armed_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else armed_q <= 1'b1;
  end

  assign q_o = stg_q[STAGES-1];

  // R3: first stage captures the pin value of the previous edge
  a_r3_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (stg_q[0] == $past(d_i)));
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int unsigned NLINES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lvl_i,
  input  logic [NLINES-1:0] pol_i,
  input  logic [NLINES-1:0] clr_i,
  input  logic [NLINES-1:0] en_i,
  output logic [NLINES-1:0] status_o,
  output logic              irq_o
);
  logic [NLINES-1:0] hit;
  logic [NLINES-1:0] stat_q;

  assign hit = lvl_i ^ pol_i;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)        stat_q[i] <= 1'b0;
      else if (clr_i[i]) stat_q[i] <= 1'b0;
      else if (hit[i])   stat_q[i] <= 1'b1;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & en_i);

  // R4: an active, uncleared line is pending after the edge
  a_r4_latch_active: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~clr_i) != '0) |=> ((stat_q & $past(hit & ~clr_i)) == $past(hit & ~clr_i)));

  // R5: a cleared bit reads zero after the clearing edge
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((stat_q & $past(clr_i)) == '0));

  // R4: a pending bit not cleared stays pending
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~clr_i) != '0) |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned NLINES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] addr_i,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NLINES-1:0]  din_i,
  input  logic [NLINES-1:0]  status_i,
  output logic [NLINES-1:0]  dout_o,
  output logic [NLINES-1:0]  oe_o,
  output logic [NLINES-1:0]  en_o,
  output logic [NLINES-1:0]  pol_o,
  output logic [NLINES-1:0]  clr_o
);
  localparam logic [REG_W-1:0] T0_KEEP = type_keep_mask(0, NLINES);
  localparam logic [REG_W-1:0] T1_KEEP = type_keep_mask(1, NLINES);
  localparam int unsigned      PAD_W   = REG_W - NLINES;

  logic [NLINES-1:0] dout_q, oe_q, en_q;
  logic [REG_W-1:0]  type0_q, type1_q, mux_q;
  logic              wr_dout, wr_oe, wr_stat, wr_t0, wr_en, wr_t1, wr_mux;

  assign wr_dout = wr_i && (addr_i == RG_DOUT);
  assign wr_oe   = wr_i && (addr_i == RG_OE);
  assign wr_stat = wr_i && (addr_i == RG_STAT);
  assign wr_t0   = wr_i && (addr_i == RG_TYPE0);
  assign wr_en   = wr_i && (addr_i == RG_EN);
  assign wr_t1   = wr_i && (addr_i == RG_TYPE1);
  assign wr_mux  = wr_i && (addr_i == RG_MUX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= '0;
      en_q    <= '0;
      type0_q <= '0;
      type1_q <= '0;
      mux_q   <= '0;
    end else begin
      if (wr_dout) dout_q  <= wdata_i[NLINES-1:0];
      if (wr_oe)   oe_q    <= wdata_i[NLINES-1:0];
      if (wr_en)   en_q    <= wdata_i[NLINES-1:0];
      if (wr_t0)   type0_q <= wdata_i & T0_KEEP;
      if (wr_t1)   type1_q <= wdata_i & T1_KEEP;
      if (wr_mux)  mux_q   <= wdata_i;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_pol
    assign pol_o[i] = pol_bit(type0_q, type1_q, i);
  end

  assign clr_o  = wr_stat ? wdata_i[NLINES-1:0] : '0;
  assign dout_o = dout_q;
  assign oe_o   = oe_q;
  assign en_o   = en_q;

  always_comb begin
    unique case (addr_i)
      RG_DOUT:  rdata_o = {{PAD_W{1'b0}}, dout_q};
      RG_OE:    rdata_o = {{PAD_W{1'b0}}, oe_q};
      RG_DIN:   rdata_o = {{PAD_W{1'b0}}, din_i};
      RG_STAT:  rdata_o = {{PAD_W{1'b0}}, status_i};
      RG_TYPE0: rdata_o = type0_q;
      RG_EN:    rdata_o = {{PAD_W{1'b0}}, en_q};
      RG_TYPE1: rdata_o = type1_q;
      default:  rdata_o = mux_q;
    endcase
  end

  // R10: line-wide words never show bits above the last line
  a_r10_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i inside {RG_DOUT, RG_OE, RG_DIN, RG_STAT, RG_EN}) |-> (rdata_o[REG_W-1:NLINES] == '0));

  // R9: the mux word changes only on its own write
  a_r9_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mux |=> $stable(mux_q));

  // R5: a status clear is only produced by a status write
  a_r5_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (wr_i && addr_i == RG_STAT));
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned NLINES      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NLINES-1:0]  pin_in,
  output logic [NLINES-1:0]  pin_out,
  output logic [NLINES-1:0]  pin_oe,
  output logic               irq
);
  logic [NLINES-1:0] lvl_sync, status, en_vec, pol_vec, clr_vec;

  gpio_lvl_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(lvl_sync)
  );

  gpio_lvl_regs #(.NLINES(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .din_i(lvl_sync),
    .status_i(status), .dout_o(pin_out), .oe_o(pin_oe), .en_o(en_vec),
    .pol_o(pol_vec), .clr_o(clr_vec)
  );

  gpio_lvl_irq #(.NLINES(NLINES)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync), .pol_i(pol_vec),
    .clr_i(clr_vec), .en_i(en_vec), .status_o(status), .irq_o(irq)
  );

  // R8: with every line masked the interrupt stays low
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !irq);

  // R8: a raised interrupt always has an enabled pending line behind it
  a_r8_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & en_vec) != '0));
endmodule

// File: tb/gpio_lvl_ctrl_test.sv
`timescale 1ns/1ps
module gpio_lvl_ctrl_test;
  localparam int N = 12;
  localparam logic [2:0] W_DOUT = 3'd0, W_OE = 3'd1, W_DIN = 3'd2, W_STAT = 3'd3,
                         W_T0 = 3'd4, W_EN = 3'd5, W_T1 = 3'd6, W_MUX = 3'd7;
  localparam logic [31:0] LMASK = 32'h0000_0FFF;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  logic [N-1:0] pins = '0;
  wire  [N-1:0] pout, poe;
  wire  irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [31:0] m_t0 = 0, m_t1 = 0, m_en = 0, m_stat = 0, m_dout = 0, m_oe = 0, m_mux = 0;
  logic [31:0] got;

  gpio_lvl_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq(irq)
  );

  always #2 clk = ~clk;

  // Type word 1 keeps every bit except the polarity bits of lines 12..15.
  function automatic logic [31:0] t1_store(input logic [31:0] d);
    return d & ~(32'h1 << 16 | 32'h1 << 20 | 32'h1 << 24 | 32'h1 << 28);
  endfunction

  function automatic logic [31:0] active_of(input logic [N-1:0] p,
                                            input logic [31:0] t0, input logic [31:0] t1);
    logic [31:0] a;
    a = '0;
    for (int n = 0; n < N; n++) begin
      logic pol;
      pol = (n < 8) ? t0[4*n] : t1[4*(n-8)];
      a[n] = pol ? ~p[n] : p[n];
    end
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    addr = w; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] w, output logic [31:0] d);
    addr = w;
    #1;
    d = rdata;
  endtask

  task automatic clear_all();
    pins = '0; m_t0 = 0; m_t1 = 0;
    wr_reg(W_T0, 0); wr_reg(W_T1, 0);
    step(3);
    wr_reg(W_STAT, LMASK);
    m_stat = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r, m, a;
    r = $urandom(32'h00C0FFEE);
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    for (int w = 0; w < 8; w++) begin
      rd_now(w[2:0], got);
      chk("R1 reset register", got, 32'h0);
    end
    chk("R1 pin_out", {20'h0, pout}, 0);
    chk("R1 pin_oe", {20'h0, poe}, 0);
    chk("R1 irq", {31'h0, irq}, 0);

    // R2 output and drive enable
    wr_reg(W_DOUT, 32'hFFFF_FFFF);
    rd_now(W_DOUT, got); chk("R2 dout readback", got, 32'hFFF);
    chk("R2 pin_out", {20'h0, pout}, 32'hFFF);
    wr_reg(W_OE, 32'h0000_0A5A);
    rd_now(W_OE, got); chk("R2 oe readback", got, 32'hA5A);
    chk("R2 pin_oe", {20'h0, poe}, 32'hA5A);

    // R3 two-stage synchronizer
    @(negedge clk); pins = 12'h5A3;
    step(1); rd_now(W_DIN, got); chk("R3 din after one edge", got, 0);
    step(1); rd_now(W_DIN, got); chk("R3 din after two edges", got, 32'h5A3);
    clear_all();
    rd_now(W_STAT, got); chk("R5 clear all", got, 0);

    // R4 latch while masked, R8 enable gates irq
    @(negedge clk); pins = 12'h008;
    step(4);
    rd_now(W_STAT, got); chk("R4 masked latch", got, 32'h008);
    chk("R8 masked irq", {31'h0, irq}, 0);
    wr_reg(W_EN, 32'h008);
    #1; chk("R8 irq after enable", {31'h0, irq}, 1);

    // R6 re-set while still active
    wr_reg(W_STAT, 32'h008);
    rd_now(W_STAT, got); chk("R6 reads zero after clear", got, 0);
    step(1); rd_now(W_STAT, got); chk("R6 sets again", got, 32'h008);
    chk("R6 irq back", {31'h0, irq}, 1);
    @(negedge clk); pins = '0;
    step(3);
    rd_now(W_STAT, got); chk("R4 held after level gone", got, 32'h008);
    wr_reg(W_STAT, 32'h008);
    step(2); rd_now(W_STAT, got); chk("R6 stays clear when idle", got, 0);
    chk("R8 irq low", {31'h0, irq}, 0);

    // R5 selective clear
    @(negedge clk); pins = 12'h006;
    step(4);
    @(negedge clk); pins = '0;
    step(3);
    wr_reg(W_STAT, 32'h002);
    rd_now(W_STAT, got); chk("R5 only written bits clear", got, 32'h004);
    clear_all();

    // R7 polarity positions
    wr_reg(W_T0, 32'hEEEE_EEEE);
    step(2); rd_now(W_STAT, got); chk("R7 non-polarity bits inert", got, 0);
    wr_reg(W_T0, 32'h1 << 20);
    wr_reg(W_T1, 32'h1 << 8);
    step(2); rd_now(W_STAT, got); chk("R7 active-low lines 5 and 10", got, (32'h1 << 5) | (32'h1 << 10));
    clear_all();

    // R10 type word 1 storage, R9 mux
    wr_reg(W_T1, 32'hFFFF_FFFF);
    rd_now(W_T1, got); chk("R10 type1 absent bits", got, 32'hEEEE_FFFF);
    wr_reg(W_T0, 32'hFFFF_FFFF);
    rd_now(W_T0, got); chk("R10 type0 full storage", got, 32'hFFFF_FFFF);
    wr_reg(W_MUX, 32'hDEAD_BEEF);
    rd_now(W_MUX, got); chk("R9 mux readback", got, 32'hDEAD_BEEF);
    chk("R9 mux no side effect", {20'h0, pout}, 32'hFFF);
    clear_all();
    m_en = 32'h008; m_dout = 32'hFFF; m_oe = 32'hA5A; m_mux = 32'hDEAD_BEEF;

    // Random phase
    for (int it = 0; it < 150; it++) begin
      m_t0 = $urandom; wr_reg(W_T0, m_t0);
      m_stat |= active_of(pins, m_t0, m_t1);
      m_t1 = t1_store($urandom); wr_reg(W_T1, m_t1 | 32'h1111_0000);
      m_stat |= active_of(pins, m_t0, m_t1);
      m_en = $urandom & LMASK; wr_reg(W_EN, m_en | 32'hF000_0000);
      m_dout = $urandom; wr_reg(W_DOUT, m_dout); m_dout &= LMASK;
      m_oe = $urandom; wr_reg(W_OE, m_oe); m_oe &= LMASK;
      if (it % 10 == 0) begin
        m_mux = $urandom; wr_reg(W_MUX, m_mux);
        rd_now(W_MUX, got); chk("R9 random mux", got, m_mux);
      end
      m_stat |= active_of(pins, m_t0, m_t1);
      @(negedge clk); pins = $urandom;
      m_stat |= active_of(pins, m_t0, m_t1);
      step(4);
      rd_now(W_DIN, got); chk("R3 random din", got, {20'h0, pins});
      rd_now(W_T1, got); chk("R10 random type1", got, m_t1);
      rd_now(W_EN, got); chk("R10 random enable pad", got, m_en);
      rd_now(W_DOUT, got); chk("R2 random dout", got, m_dout);
      chk("R2 random pin_oe", {20'h0, poe}, m_oe);
      rd_now(W_STAT, got); chk("R4 R7 random status", got, m_stat);
      chk("R8 random irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
      if ($urandom % 2 == 1) begin
        m = $urandom;
        wr_reg(W_STAT, m);
        rd_now(W_STAT, got); chk("R5 random clear", got, m_stat & ~m);
        a = active_of(pins, m_t0, m_t1);
        m_stat = (m_stat & ~m) | a;
        step(1);
        rd_now(W_STAT, got); chk("R6 random re-set", got, m_stat);
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule